// File: doc/BRIEF.md
# Programmable Watchdog Timer Unit

This block watches for a processor that has stopped servicing it. Software loads one 8-bit control byte over a simple synchronous register bus. The byte holds a 5-bit multiplier, a 2-bit resolution code and a steering bit. The unit then counts down on a one-cycle 16 Hz tick enable. The countdown starts again from the full programmed period whenever software rewrites the control byte, or whenever the external kick line changes level in either direction.

If the count runs out, the unit sets a sticky flag that software reads and clears through the flags register. The steering bit then picks one of two results. With steering 0, a latched active-low interrupt stays asserted until software writes 0x00. With steering 1, the unit emits an active-low reset pulse of fixed length and clears its own programming.

The interrupt pin is shared with a frequency-test output, which has lower priority than the watchdog interrupt. A power-down input stands in for the supply monitor: while it is high, the watchdog is disabled and its programming is wiped.

Top module: `wdog_unit`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rst_pulse_n is 1, irq_oe is 0, and the flags, control and test registers all read 0x00.
- R2: The control byte at address 1 has this layout: bit 7 is steering, bits 6:2 are the multiplier M, and bits 1:0 are the resolution code. The resolution code gives a length in ticks of 1, 4, 16 or 64 for codes 0, 1, 2 and 3. With M nonzero, the timer expires on the tick numbered M times that length after the last restart. Expiry sets bit 7 of the flags register at address 0.
- R3: Any read of address 0 clears the flag bit after returning it, so a second read returns 0x00.
- R4: A multiplier of zero keeps the timer idle, and it never expires however many ticks arrive.
- R5: Every rising edge and every falling edge of kick_in, after a two-flop synchronizer, restarts the countdown from the full period.
- R6: Every write to address 1 restarts the countdown from the full period of the byte written.
- R7: On expiry with steering 0, the unit holds irq_n at 0 with irq_oe at 1. A write of a nonzero byte to address 1 leaves it asserted. Only a write of 0x00 to address 1 releases it.
- R8: On expiry with steering 1, rst_pulse_n goes low for exactly 2 ticks. In the same cycle as expiry, the control register and the frequency-test enable (bit 0 of address 2) are both cleared.
- R9: While the frequency-test enable is 1 and no watchdog interrupt is latched, irq_oe is 1 and irq_n follows ft_sig. A latched watchdog interrupt overrides this and forces irq_n to 0.
- R10: While pwr_down is 1, the control register reads 0x00, writes to it are ignored, and the timer neither counts nor expires.
- R11: After one expiry the timer stays idle, and it does not expire again until it is restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle 16 Hz count enable |
| kick_in | input | 1 | Asynchronous kick line; either edge restarts the timer |
| pwr_down | input | 1 | Power-down: disables and clears the watchdog |
| ft_sig | input | 1 | Frequency-test waveform for the shared pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (only the flags register has read side effects) |
| bus_addr | input | 2 | Register address: 0 flags, 1 control, 2 test enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on the address) |
| irq_n | output | 1 | Shared interrupt / frequency-test pin value, active low |
| irq_oe | output | 1 | Output enable for irq_n (0 means released / high-impedance) |
| rst_pulse_n | output | 1 | Active-low reset pulse produced on a steered expiry |

## Verification
The countdown is driven with a table of control bytes. The table covers every resolution code and multipliers of 1, 3 and 31. Each entry stops either one tick short of the expected period or exactly on it, so an off-by-one in the period, a wrong resolution shift or a misplaced field shows up as a flag in the wrong place. Zero-multiplier entries with long tick runs separate "idle" from "very long period".

Directed sequences follow. One restarts the timer just before expiry with a kick rising edge, a kick falling edge and a control rewrite; each must push expiry one full period out. Another alternates the steering bit to separate the latched interrupt from the fixed-length reset pulse. A third toggles ft_sig under the interrupt to show which source owns the shared pin.

// File: rtl/wdog_pkg.sv
// Package: shared constants, control-byte layout and the period calculation
// for the watchdog unit. Assumes an 8-bit control byte.
package wdog_pkg;

    localparam int MULT_W    = 5;   // multiplier field width
    localparam int RES_W     = 2;   // resolution code width
    localparam int RES_STEP  = 2;   // each resolution code step multiplies by 4
    localparam int CNT_W     = MULT_W + RES_STEP * ((1 << RES_W) - 1);

    localparam logic [1:0] ADDR_FLAGS = 2'd0;
    localparam logic [1:0] ADDR_WDCTL = 2'd1;
    localparam logic [1:0] ADDR_TEST  = 2'd2;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wdctl_t;

    // Timeout in ticks: multiplier shifted left by RES_STEP per resolution code.
    function automatic logic [CNT_W-1:0] period_ticks(input logic [MULT_W-1:0] m,
                                                      input logic [RES_W-1:0]  r);
        return CNT_W'(m) << (RES_STEP * int'(r));
    endfunction

endpackage

// File: rtl/wdog_kick_sync.sv
// Kick synchronizer: brings the asynchronous kick line into the clock domain
// through STAGES flops, then flags any change of level (either direction).
// Assumes the kick line stays stable for several clock cycles between edges.
module wdog_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_async,
    output logic kick_edge
);
    localparam int LAST = STAGES;

    logic [LAST:0] shf;

    // Shift chain: synchronizer stages plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shf <= '0;
        else        shf <= {shf[LAST-1:0], kick_async};
    end

    assign kick_edge = shf[LAST] ^ shf[LAST-1];

endmodule

// File: rtl/wdog_timer.sv
// Countdown core: loads the period on restart, decrements on each tick while
// running and gives a one-cycle expire strobe on the final tick, then idles.
// Assumes halt (power-down) overrides everything and restart beats expiry.
module wdog_timer
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [MULT_W-1:0] ld_mult,
    input  logic [RES_W-1:0]  ld_res,
    input  logic              halt,
    output logic              expire
);
    logic [CNT_W-1:0] cnt;
    logic             running;
    logic             last_tick;

    assign last_tick = running && tick && (cnt == CNT_W'(1));
    assign expire    = last_tick && !restart && !halt;

    // Count state: reload on restart, step down on ticks, stop after expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || halt) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (restart) begin
            cnt     <= period_ticks(ld_mult, ld_res);
            running <= |ld_mult;
        end else if (running && tick) begin
            if (cnt == CNT_W'(1)) begin
                cnt     <= '0;
                running <= 1'b0;
            end else begin
                cnt     <= cnt - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/wdog_outmux.sv
// Output stage: latches the steered interrupt, times the fixed reset pulse
// in ticks, and arbitrates the shared pin between watchdog and frequency test.
// Assumes expire is a single-cycle strobe.
module wdog_outmux #(
    parameter int PULSE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic expire,
    input  logic steer,
    input  logic irq_clr,
    input  logic halt,
    input  logic ft_en,
    input  logic ft_sig,
    output logic irq_lat,
    output logic irq_n,
    output logic irq_oe,
    output logic rst_pulse_n
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    logic [PW-1:0] pulse_cnt;

    // Interrupt latch: set by an unsteered expiry, released by clear or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || halt || irq_clr) irq_lat <= 1'b0;
        else if (expire && !steer)     irq_lat <= 1'b1;
    end

    // Reset pulse length counter, measured in ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                            pulse_cnt <= '0;
        else if (expire && steer)              pulse_cnt <= PW'(PULSE_TICKS);
        else if (tick && (pulse_cnt != '0))    pulse_cnt <= pulse_cnt - PW'(1);
    end

    assign rst_pulse_n = (pulse_cnt == '0);

    // Pin arbitration: watchdog interrupt first, then frequency test, else released.
    always_comb begin
        if (irq_lat) begin
            irq_oe = 1'b1;
            irq_n  = 1'b0;
        end else if (ft_en) begin
            irq_oe = 1'b1;
            irq_n  = ft_sig;
        end else begin
            irq_oe = 1'b0;
            irq_n  = 1'b1;
        end
    end

endmodule

// File: rtl/wdog_unit.sv
// Watchdog unit top: register file (flags, control, test enable), restart
// logic and the wiring of synchronizer, countdown core and output stage.
// Assumes a single-cycle bus: writes take effect at the strobed edge and
// read data is valid combinationally in the same cycle.
module wdog_unit
    import wdog_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       kick_in,
    input  logic       pwr_down,
    input  logic       ft_sig,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_n,
    output logic       irq_oe,
    output logic       rst_pulse_n
);
    wdctl_t ctl_q;
    wdctl_t ld_ctl;
    logic   ft_en;
    logic   wdf;
    logic   kick_edge;
    logic   expire;
    logic   irq_lat;
    logic   wr_ctl;
    logic   wr_test;
    logic   rd_flags;
    logic   restart;
    logic   irq_clr;

    assign wr_ctl   = bus_wr && (bus_addr == ADDR_WDCTL) && !pwr_down;
    assign wr_test  = bus_wr && (bus_addr == ADDR_TEST);
    assign rd_flags = bus_rd && (bus_addr == ADDR_FLAGS);
    assign restart  = wr_ctl || (kick_edge && !pwr_down);
    assign irq_clr  = wr_ctl && (bus_wdata == 8'h00);
    assign ld_ctl   = wr_ctl ? wdctl_t'(bus_wdata) : ctl_q;

    // Control register: written by software, wiped on power-down or steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down)        ctl_q <= '0;
        else if (wr_ctl)               ctl_q <= wdctl_t'(bus_wdata);
        else if (expire && ctl_q.steer) ctl_q <= '0;
    end

    // Frequency-test enable: software bit, cleared by a steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ft_en <= 1'b0;
        else if (expire && ctl_q.steer) ft_en <= 1'b0;
        else if (wr_test)               ft_en <= bus_wdata[0];
    end

    // Watchdog flag: set on expiry, cleared by reading the flags register.
    always_ff @(posedge clk) begin
        if (!rst_n)        wdf <= 1'b0;
        else if (expire)   wdf <= 1'b1;
        else if (rd_flags) wdf <= 1'b0;
    end

    // Read data mux.
    always_comb begin
        case (bus_addr)
            ADDR_FLAGS: bus_rdata = {wdf, 7'b0};
            ADDR_WDCTL: bus_rdata = ctl_q;
            ADDR_TEST:  bus_rdata = {7'b0, ft_en};
            default:    bus_rdata = 8'h00;
        endcase
    end

    wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_async (kick_in),
        .kick_edge  (kick_edge)
    );

    wdog_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .restart (restart),
        .ld_mult (ld_ctl.mult),
        .ld_res  (ld_ctl.res),
        .halt    (pwr_down),
        .expire  (expire)
    );

    wdog_outmux #(.PULSE_TICKS(PULSE_TICKS)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .expire      (expire),
        .steer       (ctl_q.steer),
        .irq_clr     (irq_clr),
        .halt        (pwr_down),
        .ft_en       (ft_en),
        .ft_sig      (ft_sig),
        .irq_lat     (irq_lat),
        .irq_n       (irq_n),
        .irq_oe      (irq_oe),
        .rst_pulse_n (rst_pulse_n)
    );

endmodule

// File: rtl/wdog_unit_chk.sv
// Checker for wdog_unit: temporal properties over ports and internal state,
// attached through bind. Assumes the synchronous active-low reset of the top.
module wdog_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_down,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] ctl_q,
    input logic       expire,
    input logic       irq_lat,
    input logic       irq_n,
    input logic       irq_oe,
    input logic       rst_pulse_n
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (rst_pulse_n && !irq_oe)); // R1
    AST_ZERO_MULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (ctl_q[6:2] == 5'd0) |-> !expire); // R4
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_lat && !pwr_down && !(bus_wr && bus_addr == 2'd1 && bus_wdata == 8'h00)) |=> irq_lat); // R7
    AST_PULSE_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) $fell(rst_pulse_n) |-> $past(expire)); // R8
    AST_IRQ_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n) irq_lat |-> (irq_oe && !irq_n)); // R9
    AST_PWRDN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) pwr_down |=> (ctl_q == 8'h00)); // R10
    AST_PWRDN_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n) pwr_down |-> !expire); // R10
endmodule

bind wdog_unit wdog_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_down    (pwr_down),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ctl_q       (ctl_q),
    .expire      (expire),
    .irq_lat     (irq_lat),
    .irq_n       (irq_n),
    .irq_oe      (irq_oe),
    .rst_pulse_n (rst_pulse_n)
);

// File: tb/tb_wdog_unit.sv
// Bench for wdog_unit: a vector table of control bytes and tick counts, then
// directed tests for reset, restarts, steering, pin sharing and power-down.
module tb_wdog_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    // {control byte, ticks to apply, expected flag}
    localparam logic [23:0] VEC [NV] = '{
        {8'h04, 12'd0,    4'd0}, {8'h04, 12'd1,    4'd1},
        {8'h0D, 12'd11,   4'd0}, {8'h0D, 12'd12,   4'd1},
        {8'h0E, 12'd47,   4'd0}, {8'h0E, 12'd48,   4'd1},
        {8'h07, 12'd63,   4'd0}, {8'h07, 12'd64,   4'd1},
        {8'h7C, 12'd30,   4'd0}, {8'h7C, 12'd31,   4'd1},
        {8'h7F, 12'd1984, 4'd1}, {8'h03, 12'd200,  4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       kick_in = 1'b0;
    logic       pwr_down = 1'b0;
    logic       ft_sig = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_n, irq_oe, rst_pulse_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_unit dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .kick_in(kick_in),
        .pwr_down(pwr_down), .ft_sig(ft_sig), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .irq_oe(irq_oe), .rst_pulse_n(rst_pulse_n)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic do_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick16 = 1'b1;
            @(negedge clk); tick16 = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 rst_pulse_n", {7'b0, rst_pulse_n}, 8'h01);
        check("R1 irq_oe", {7'b0, irq_oe}, 8'h00);
        rd(2'd0, rv); check("R1 flags", rv, 8'h00);
        rd(2'd1, rv); check("R1 control", rv, 8'h00);
        rd(2'd2, rv); check("R1 test", rv, 8'h00);

        // R2 / R4 table walk
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, VEC[i][23:16]);
            do_tick(int'(VEC[i][15:4]));
            check(VEC[i][0] ? "R2 pin at expiry" : "R4 pin idle",
                  {6'b0, irq_oe, irq_n}, VEC[i][0] ? 8'h02 : 8'h01);
            rd(2'd0, rv);
            check(VEC[i][0] ? "R2 flag at period" : "R2 R4 flag early", rv, {VEC[i][0], 7'b0});
            wr(2'd1, 8'h00);
        end

        // R3 read clears and R11 idle after expiry
        wr(2'd1, 8'h05); do_tick(4);
        rd(2'd0, rv); check("R3 first read", rv, 8'h80);
        rd(2'd0, rv); check("R3 second read", rv, 8'h00);
        do_tick(12);
        rd(2'd0, rv); check("R11 no re-expiry", rv, 8'h00);
        wr(2'd1, 8'h00);

        // R5 rising kick edge restarts
        wr(2'd1, 8'h05); do_tick(3);
        kick_in = 1'b1; repeat (5) @(negedge clk);
        do_tick(3); rd(2'd0, rv); check("R5 rise restart", rv, 8'h00);
        do_tick(1); rd(2'd0, rv); check("R5 rise expiry", rv, 8'h80);
        wr(2'd1, 8'h00);
        // R5 falling kick edge restarts
        wr(2'd1, 8'h05); do_tick(3);
        kick_in = 1'b0; repeat (5) @(negedge clk);
        do_tick(3); rd(2'd0, rv); check("R5 fall restart", rv, 8'h00);
        do_tick(1); rd(2'd0, rv); check("R5 fall expiry", rv, 8'h80);
        wr(2'd1, 8'h00);

        // R6 control rewrite restarts
        wr(2'd1, 8'h05); do_tick(3);
        wr(2'd1, 8'h05); do_tick(3);
        rd(2'd0, rv); check("R6 rewrite restart", rv, 8'h00);
        do_tick(1); rd(2'd0, rv); check("R6 rewrite expiry", rv, 8'h80);
        wr(2'd1, 8'h00);

        // R9 frequency test on the shared pin, R7 latch and release
        wr(2'd2, 8'h01);
        ft_sig = 1'b1; @(negedge clk);
        check("R9 ft high", {6'b0, irq_oe, irq_n}, 8'h03);
        ft_sig = 1'b0; @(negedge clk);
        check("R9 ft low", {6'b0, irq_oe, irq_n}, 8'h02);
        ft_sig = 1'b1;
        wr(2'd1, 8'h04); do_tick(1);
        check("R9 watchdog wins", {6'b0, irq_oe, irq_n}, 8'h02);
        wr(2'd1, 8'h05);
        check("R7 nonzero write holds", {6'b0, irq_oe, irq_n}, 8'h02);
        wr(2'd1, 8'h00);
        check("R7 zero write releases", {6'b0, irq_oe, irq_n}, 8'h03);
        wr(2'd2, 8'h00);
        check("R9 ft off releases pin", {7'b0, irq_oe}, 8'h00);
        rd(2'd0, rv);

        // R8 steered reset pulse
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h84); do_tick(1);
        check("R8 pulse low", {7'b0, rst_pulse_n}, 8'h00);
        check("R8 no irq", {7'b0, irq_lat_free()}, 8'h01);
        rd(2'd1, rv); check("R8 control cleared", rv, 8'h00);
        rd(2'd2, rv); check("R8 ft cleared", rv, 8'h00);
        rd(2'd0, rv); check("R8 flag set", rv, 8'h80);
        do_tick(1); check("R8 pulse still low", {7'b0, rst_pulse_n}, 8'h00);
        do_tick(1); check("R8 pulse ends", {7'b0, rst_pulse_n}, 8'h01);

        // R10 power-down
        wr(2'd1, 8'h05);
        @(negedge clk); pwr_down = 1'b1;
        rd(2'd1, rv); check("R10 control cleared", rv, 8'h00);
        wr(2'd1, 8'h05);
        rd(2'd1, rv); check("R10 write ignored", rv, 8'h00);
        do_tick(10);
        rd(2'd0, rv); check("R10 no expiry", rv, 8'h00);
        @(negedge clk); pwr_down = 1'b0;
        do_tick(10);
        rd(2'd0, rv); check("R10 stays idle", rv, 8'h00);

        finish_run();
    end

    // Pin released (steered expiry must not touch the interrupt pin).
    function automatic logic irq_lat_free();
        return !irq_oe;
    endfunction

endmodule